// File: doc/BRIEF.md
# Fast Overcurrent Trip Filter

This block takes the one-bit stream of a single delta-sigma modulator and turns it into a coarse current estimate fast enough to protect a power stage. A logic one counts as +1 and a logic zero counts as -1, so a stream with half ones reads as zero current. A steady run of ones reads as full positive current, and a steady run of zeros reads as full negative current. A second-order sinc decimator reduces the stream by a selectable ratio. It can optionally add the result from two output periods earlier, which deepens the notches and doubles the gain.

Each result that has settled is published as a signed word with a one-cycle strobe. The same result is compared against an upper and a lower signed limit. When a result goes beyond either limit, a sticky trip flag is set. The flag stays set until a clear pulse arrives at a time when the most recent result was back inside the limits.

The mode and decimation ratio are taken while reset is held. Any later change to them restarts the filter and the settle count, and the bit presented on that edge is dropped.

Top module: `fast_trip_filter`

## Requirements
- R1: `y_valid` is a single-cycle pulse. After settling it pulses once per decimation period: on the edge that takes the last bit of each period.
- R2: In plain mode (`cfg_fast`=0), the result on the edge that takes bit t, with t a multiple of N, is sum over k=0..2N-2 of w(k)*x(t-k). Here w(k)=k+1 for k<N and w(k)=2N-1-k otherwise. x is +1 for a one and -1 for a zero. Bits from before the latest restart count as 0.
- R3: In fast mode (`cfg_fast`=1), the result is the plain-mode value at bit t plus the plain-mode value at bit t-2N.
- R4: The decimation ratio is N = 4 shifted left by `cfg_osr_sel` (0:4, 1:8, 2:16, 3:32). A steady ones stream settles to N*N in plain mode and 2*N*N in fast mode.
- R5: Counting from a restart, the first published result is at decimation index 2 in plain mode and index 4 in fast mode. No strobe comes before that.
- R6: `trip` is set on the edge that publishes a result strictly greater than `thr_hi` or strictly less than `thr_lo`. A result equal to a limit does not set it.
- R7: Once set, `trip` stays set until `clr` is high on an edge. The bench observes that it stays set after the results fall back inside the limits.
- R8: `clr` is ignored while the most recent result is still beyond a limit, including a result taken on the same edge. It takes effect once that result is back inside the limits.
- R9: A change of `cfg_fast` or `cfg_osr_sel` while running restarts the filter. The bit on that edge is dropped and no strobe follows it. A ratio change takes effect for the next result.
- R10: After synchronous reset, `trip` and `y_valid` are 0 and `y_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_fast | input | 1 | 0 plain second-order sinc, 1 with added two-period-delayed result |
| cfg_osr_sel | input | SEL_W | Decimation ratio select, N = 4 << value |
| bit_in | input | 1 | Modulator output bit |
| thr_hi | input | W | Signed upper trip limit |
| thr_lo | input | W | Signed lower trip limit |
| clr | input | 1 | Trip clear request |
| y_out | output | W | Signed filtered result |
| y_valid | output | 1 | Strobe marking a new settled result |
| trip | output | 1 | Latched overcurrent flag |

## Verification
A broken integrator or comb register shows up on `y_out` at the first strobe after settling, so within two or four decimation periods of a restart. The bench compares every strobed word against an independent weighted-window sum of the bits it sent. A miscounted phase or settle counter moves the strobe by whole cycles, and the bench catches this because it checks the strobe on every cycle. Faults in the trip latch or its clear logic show up on `trip` within one cycle of a clear pulse or a limit crossing.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_FAST  = 1'b1
  } ftf_mode_e;

  // Log2 of the decimation ratio for a select code, clamped to the supported maximum.
  function automatic int ratio_log2(input int sel, input int min_l, input int max_l);
    int v;
    v = min_l + sel;
    if (v > max_l) v = max_l;
    return v;
  endfunction

  // Number of decimated samples needed before the output window is fully populated.
  function automatic int settle_periods(input logic fast);
    return (fast == MODE_FAST) ? 4 : 2;
  endfunction

endpackage

// File: rtl/ftf_integ.sv
module ftf_integ #(
  parameter int W    = 13,
  parameter int PH_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                bit_in,
  input  logic [PH_W-1:0]     last_phase,
  output logic signed [W-1:0] sum_nx,
  output logic                dec
);
  logic signed [W-1:0] acc1, acc2, acc1_nx, step;
  logic [PH_W-1:0]     phase;

  // +1 for a one, -1 for a zero
  assign step    = {{(W-1){~bit_in}}, 1'b1};
  assign acc1_nx = acc1 + step;
  assign sum_nx  = acc2 + acc1_nx;
  assign dec     = (phase == last_phase) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc1  <= '0;
      acc2  <= '0;
      phase <= '0;
    end else begin
      acc1  <= acc1_nx;
      acc2  <= sum_nx;
      phase <= dec ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/ftf_comb.sv
module ftf_comb #(
  parameter int W = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                dec,
  input  logic                fast,
  input  logic signed [W-1:0] sum_in,
  output logic signed [W-1:0] y_nx,
  output logic                take,
  output logic signed [W-1:0] y_q,
  output logic                valid_q
);
  import ftf_pkg::*;

  logic signed [W-1:0] prev_sum, prev_c1, hist1, hist2, c1, c2;
  logic [2:0]          cnt, cnt_nx;

  assign c1     = sum_in - prev_sum;
  assign c2     = c1 - prev_c1;
  assign y_nx   = fast ? c2 + hist2 : c2;
  assign cnt_nx = (cnt >= 3'd4) ? cnt : cnt + 3'd1;
  assign take   = dec && (int'(cnt_nx) >= settle_periods(fast));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      prev_sum <= '0;
      prev_c1  <= '0;
      hist1    <= '0;
      hist2    <= '0;
      cnt      <= '0;
      y_q      <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) y_q <= y_nx;
      if (dec) begin
        prev_sum <= sum_in;
        prev_c1  <= c1;
        hist1    <= c2;
        hist2    <= hist1;
        cnt      <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/ftf_trip.sv
module ftf_trip #(
  parameter int W = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                take,
  input  logic signed [W-1:0] y_nx,
  input  logic signed [W-1:0] thr_hi,
  input  logic signed [W-1:0] thr_lo,
  input  logic                clr,
  output logic                trip,
  output logic                hot_now
);
  logic over, hot;

  assign over    = take && ((y_nx > thr_hi) || (y_nx < thr_lo));
  assign hot_now = take ? over : hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      trip <= 1'b0;
      hot  <= 1'b0;
    end else begin
      if (over)                trip <= 1'b1;
      else if (clr && !hot_now) trip <= 1'b0;
      if (restart)   hot <= 1'b0;
      else if (take) hot <= over;
    end
  end
endmodule

// File: rtl/fast_trip_filter.sv
module fast_trip_filter #(
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5,
  parameter int SEL_W    = 2,
  parameter int W        = 2 * MAX_LOG2 + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_fast,
  input  logic [SEL_W-1:0]    cfg_osr_sel,
  input  logic                bit_in,
  input  logic signed [W-1:0] thr_hi,
  input  logic signed [W-1:0] thr_lo,
  input  logic                clr,
  output logic signed [W-1:0] y_out,
  output logic                y_valid,
  output logic                trip
);
  import ftf_pkg::*;

  localparam int PH_W = MAX_LOG2;

  logic                fast_q;
  logic [SEL_W-1:0]    sel_q;
  logic                restart;
  logic [PH_W-1:0]     last_phase;
  logic signed [W-1:0] sum_nx, y_nx;
  logic                dec, take, hot_now;

  assign restart    = !rst && ((cfg_fast != fast_q) || (cfg_osr_sel != sel_q));
  assign last_phase = PH_W'((32'd1 << ratio_log2(int'(sel_q), MIN_LOG2, MAX_LOG2)) - 32'd1);

  // configuration is captured during reset and followed afterwards; any difference restarts
  always_ff @(posedge clk) begin
    fast_q <= cfg_fast;
    sel_q  <= cfg_osr_sel;
  end

  ftf_integ #(.W(W), .PH_W(PH_W)) u_integ (
    .clk(clk), .rst(rst), .restart(restart), .bit_in(bit_in),
    .last_phase(last_phase), .sum_nx(sum_nx), .dec(dec)
  );

  ftf_comb #(.W(W)) u_comb (
    .clk(clk), .rst(rst), .restart(restart), .dec(dec), .fast(fast_q),
    .sum_in(sum_nx), .y_nx(y_nx), .take(take), .y_q(y_out), .valid_q(y_valid)
  );

  ftf_trip #(.W(W)) u_trip (
    .clk(clk), .rst(rst), .restart(restart), .take(take), .y_nx(y_nx),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .clr(clr), .trip(trip), .hot_now(hot_now)
  );
endmodule

// File: rtl/fast_trip_filter_chk.sv
module fast_trip_filter_chk #(
  parameter int W = 13
) (
  input logic                clk,
  input logic                rst,
  input logic                restart,
  input logic                hot_now,
  input logic                clr,
  input logic signed [W-1:0] thr_hi,
  input logic signed [W-1:0] thr_lo,
  input logic signed [W-1:0] y_out,
  input logic                y_valid,
  input logic                trip
);
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !y_valid);

  a_r6_trip_on_excess: assert property (@(posedge clk) disable iff (rst)
    (y_valid && ((y_out > $past(thr_hi)) || (y_out < $past(thr_lo)))) |-> trip);

  a_r6_rise_with_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(trip) |-> y_valid);

  a_r7_latched: assert property (@(posedge clk) disable iff (rst)
    (trip && !clr) |=> trip);

  a_r8_clear_blocked: assert property (@(posedge clk) disable iff (rst)
    (clr && hot_now) |=> trip);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!trip && !y_valid && (y_out == '0)));
endmodule

bind fast_trip_filter fast_trip_filter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .hot_now(hot_now), .clr(clr),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .y_out(y_out), .y_valid(y_valid), .trip(trip)
);

// File: tb/test_fast_trip_filter.sv
`timescale 1ns/100ps
module test_fast_trip_filter;
  localparam int W = 13;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cfg_fast = 1'b0;
  logic [1:0]          cfg_osr_sel = 2'd0;
  logic                bit_in = 1'b0;
  logic signed [W-1:0] thr_hi = '0;
  logic signed [W-1:0] thr_lo = '0;
  logic                clr = 1'b0;
  logic signed [W-1:0] y_out;
  logic                y_valid;
  logic                trip;

  int errors = 0;
  int checks = 0;
  int hist[0:4095];
  int tcount = 0;
  int cur_n = 4;
  bit cur_fast = 0;
  int first_valid = -1;

  always #2.5 clk = ~clk;

  fast_trip_filter i_fast_trip_filter (
    .clk(clk), .rst(rst), .cfg_fast(cfg_fast), .cfg_osr_sel(cfg_osr_sel),
    .bit_in(bit_in), .thr_hi(thr_hi), .thr_lo(thr_lo), .clr(clr),
    .y_out(y_out), .y_valid(y_valid), .trip(trip)
  );

  // fast, sel, period, ones per period, thr_hi, thr_lo, expected trip
  localparam int NV = 9;
  localparam int VEC [NV][7] = '{
    '{0, 0, 1, 1,    10,   -10, 1},
    '{0, 1, 1, 0,   100,   -50, 1},
    '{0, 1, 2, 1,    20,   -20, 0},
    '{1, 0, 1, 1,    31,   -31, 1},
    '{1, 0, 1, 1,    32,   -32, 0},
    '{0, 2, 1, 0,   256,  -256, 0},
    '{1, 3, 4, 3,  2000, -2000, 0},
    '{0, 3, 1, 1,  1000, -1000, 1},
    '{1, 1, 5, 1,   200,   -40, 1}
  };

  function automatic int plain_y(int t, int n);
    int s = 0;
    for (int k = 0; k < 2*n-1; k++) begin
      int idx = t - k;
      int w = (k < n) ? k + 1 : 2*n - 1 - k;
      if (idx >= 1) s += w * hist[idx];
    end
    return s;
  endfunction

  function automatic int model_y(int t, int n, bit fast);
    return fast ? plain_y(t, n) + plain_y(t - 2*n, n) : plain_y(t, n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one bit at the negedge, let one edge consume it, check at the next negedge
  task automatic step(input bit b);
    bit exp_v;
    bit_in = b;
    @(posedge clk);
    tcount++;
    hist[tcount] = b ? 1 : -1;
    @(negedge clk);
    exp_v = (tcount % cur_n == 0) && (tcount / cur_n >= (cur_fast ? 4 : 2));
    if (y_valid && first_valid < 0) first_valid = tcount;
    if (exp_v || y_valid) begin
      check(y_valid == exp_v, "R1 R5 strobe timing", int'(y_valid), int'(exp_v));
      if (exp_v) check(int'(y_out) == model_y(tcount, cur_n, cur_fast),
                       cur_fast ? "R3 fast result" : "R2 plain result",
                       int'(y_out), model_y(tcount, cur_n, cur_fast));
    end
  endtask

  task automatic do_reset(input bit f, input int sel);
    @(negedge clk);
    rst = 1'b1; cfg_fast = f; cfg_osr_sel = 2'(sel); clr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    tcount = 0; cur_n = 4 << sel; cur_fast = f; first_valid = -1;
  endtask

  task automatic restart_cfg(input bit f, input int sel);
    cfg_fast = f; cfg_osr_sel = 2'(sel); bit_in = 1'b1;
    @(posedge clk);
    tcount = 0; cur_n = 4 << sel; cur_fast = f; first_valid = -1;
    @(negedge clk);
    check(y_valid == 1'b0, "R9 no strobe after restart", int'(y_valid), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset(0, 0);
    check(trip == 1'b0, "R10 trip after reset", int'(trip), 0);
    check(y_valid == 1'b0, "R10 strobe after reset", int'(y_valid), 0);
    check(y_out == '0, "R10 result after reset", int'(y_out), 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int n;
      do_reset(VEC[v][0] != 0, VEC[v][1]);
      thr_hi = W'(VEC[v][4]);
      thr_lo = W'(VEC[v][5]);
      n = cur_n;
      for (int i = 0; i < 6*n; i++) step(((tcount % VEC[v][2]) < VEC[v][3]));
      check(first_valid == n * (cur_fast ? 4 : 2), "R5 first strobe index", first_valid,
            n * (cur_fast ? 4 : 2));
      check(trip == VEC[v][6][0], "R6 trip vs limits", int'(trip), VEC[v][6]);
    end

    // R4 steady ones levels
    do_reset(0, 2);
    for (int i = 0; i < 48; i++) step(1'b1);
    check(int'(y_out) == 256, "R4 plain full scale N=16", int'(y_out), 256);
    do_reset(1, 1);
    for (int i = 0; i < 40; i++) step(1'b1);
    check(int'(y_out) == 128, "R4 fast full scale N=8", int'(y_out), 128);

    // R7 R8 latch and clear priority
    do_reset(0, 0);
    thr_hi = W'(10); thr_lo = W'(-10);
    for (int i = 0; i < 12; i++) step(1'b1);
    check(trip == 1'b1, "R6 trip set by ones", int'(trip), 1);
    step(1'b1);
    clr = 1'b1; step(1'b1); clr = 1'b0;
    check(trip == 1'b1, "R8 clear ignored while over", int'(trip), 1);
    thr_hi = W'(100);
    for (int i = 0; i < 3; i++) step(1'b1);
    check(trip == 1'b1, "R7 held after back in range", int'(trip), 1);
    step(1'b1);
    clr = 1'b1; step(1'b1); clr = 1'b0;
    check(trip == 1'b0, "R8 clear accepted in range", int'(trip), 0);

    // R9 restart on a ratio change while running, trip kept
    thr_hi = W'(10);
    for (int i = 0; i < 12; i++) step(1'b1);
    thr_hi = W'(1000);
    restart_cfg(0, 1);
    for (int i = 0; i < 32; i++) step(1'b1);
    check(first_valid == 16, "R9 first strobe after restart", first_valid, 16);
    check(int'(y_out) == 64, "R9 new ratio in effect", int'(y_out), 64);
    check(trip == 1'b1, "R7 trip kept across restart", int'(trip), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule